// File: doc/BRIEF.md
# Serial-Loaded Protected Octal Output Controller

This block is the digital control core of an eight-channel switch driver that is programmed over a serial pair. A serial clock and a data line fill a shift register. Its last stage is brought out on a serial output, so several controllers can be chained on one clock and data pair and loaded with a single strobe. A level-sensitive strobe copies the shift register into an output latch, and each latch bit switches one channel drive signal on or off.

Protection is handled in digital form. Each channel has an over-current detect input. When a detect is seen on a channel that is being driven, that channel alone is latched off and a shared active-low fault flag is pulled. Both the channel latches and the flag are released by the next strobe. An 8-bit temperature code drives a global shutdown with hysteresis. This shutdown does not touch the fault flag. An active-low enable blanks all drives. The asynchronous reset acts as the power-on reset.

The serial pins, the strobe, the enable and the detect inputs come from outside and are asynchronous. They pass through two-flop synchronizers into the system clock domain. Rising edges of the serial clock are detected in that domain. The temperature code is assumed to be synchronous to `clk` already.

Top module: `octal_switch_ctrl`

## Requirements
- R1: On each detected rising edge of `ser_clk`, the register shifts by one place and `ser_din` enters the channel 0 stage. After eight edges, the first bit shifted sits in channel 7 and the last bit sits in channel 0.
- R2: `ser_dout` always shows the channel 7 stage, so it carries the bit that entered eight serial edges earlier. It changes only on a detected serial edge.
- R3: While `load_stb` is high, the output latch follows the shift register, including during shifting. While `load_stb` is low, the latch holds, and shifting has no effect on `drive`.
- R4: A latch bit of 1 turns on the matching `drive` bit (bit i belongs to channel i), and a 0 turns it off.
- R5: While `en_n` is high, all `drive` bits are 0. The latch is kept, and its pattern returns when `en_n` goes low.
- R6: If `oc_det[i]` is seen while channel i is driven and `load_stb` is low, channel i is latched off and stays off after `oc_det[i]` drops. The other channels are unaffected. A detect on a channel that is not driven is ignored.
- R7: `fault_n` is 0 while any over-current latch is set. A strobe pulse clears all over-current latches and releases `fault_n`, even if no new data was shifted in.
- R8: When `temp_code` is at or above `TRIP_C` (default 155), all drives go off. They stay off until `temp_code` falls below `TRIP_C - HYST_C` (default 145). Codes in between keep the current state.
- R9: Thermal shutdown never asserts `fault_n` and does not alter the output latch. After cooling, the drives return to the latched pattern.
- R10: While reset is asserted and right after it, `drive` is 0, `fault_n` is 1 and `ser_dout` is 0. The shift register, the output latch and the over-current latches are all cleared.
- R11: A change on a synchronized input reaches the ports within three `clk` cycles. The path is two synchronizer flops plus one state register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_din | input | 1 | Serial data in, sampled on a detected rising edge of ser_clk |
| ser_dout | output | 1 | Serial data out (channel 7 stage) for cascading |
| load_stb | input | 1 | Level-sensitive strobe: high makes the latch follow, low makes it hold |
| en_n | input | 1 | Active-low enable for all drives |
| oc_det | input | 8 | Per-channel over-current detect, active high |
| temp_code | input | 8 | Die temperature as an unsigned code, in degrees C |
| drive | output | 8 | Per-channel drive, 1 means on |
| fault_n | output | 1 | Active-low over-current fault flag |

## Verification
A wrong bit in the shift register appears on `ser_dout` once that bit reaches the last stage. After the next strobe it also appears on the matching `drive` bit. A stuck or missed over-current latch shows up within three cycles as a wrong `drive` bit and a wrong `fault_n`. A latch that a strobe fails to clear is still visible after the strobe pulse ends. A wrong thermal state is exposed by walking `temp_code` across both thresholds and through the band between them. Within three cycles the drives either blank or return to the latched pattern, and `fault_n` must stay high throughout.

// File: rtl/oswc_pkg.sv
package oswc_pkg;
  typedef enum logic {
    TH_COOL = 1'b0,
    TH_HOT  = 1'b1
  } therm_state_e;
endpackage

// File: rtl/oswc_sync.sv
module oswc_sync #(
  parameter int              W       = 4,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] meta_q, hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      hold_q <= RST_VAL;
    end else begin
      meta_q <= d_async;
      hold_q <= meta_q;
    end
  end

  assign q_sync = hold_q;
endmodule

// File: rtl/oswc_shifter.sv
module oswc_shifter #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sck_s,
  input  logic         din_s,
  output logic [N-1:0] stage_q,
  output logic         dout
);
  logic sck_prev;
  logic sck_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_prev <= 1'b0;
    else        sck_prev <= sck_s;
  end

  assign sck_rise = sck_s & ~sck_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stage_q <= '0;
    else if (sck_rise) stage_q <= {stage_q[N-2:0], din_s};
  end

  assign dout = stage_q[N-1];

  // R1: the register changes only on a detected serial edge
  a_r1_hold_no_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_rise |=> $stable(stage_q));
  // R2: the serial output takes the old next-to-last stage on an edge
  a_r2_dout_chain: assert property (@(posedge clk) disable iff (!rst_n)
    sck_rise |=> (dout == $past(stage_q[N-2])));
endmodule

// File: rtl/oswc_guard.sv
module oswc_guard #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stb_s,
  input  logic         dis_s,
  input  logic         hot,
  input  logic [N-1:0] oc_s,
  input  logic [N-1:0] stage_q,
  output logic [N-1:0] drive,
  output logic         fault_n
);
  logic [N-1:0] out_lat;
  logic [N-1:0] oc_lat;
  logic         blank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     out_lat <= '0;
    else if (stb_s) out_lat <= stage_q;
  end

  assign blank = dis_s | hot;

  for (genvar i = 0; i < N; i++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            oc_lat[i] <= 1'b0;
      else if (stb_s)        oc_lat[i] <= 1'b0;
      else if (oc_s[i] && drive[i]) oc_lat[i] <= 1'b1;
    end
    assign drive[i] = out_lat[i] & ~oc_lat[i] & ~blank;

    // R6: a set over-current latch survives until a strobe
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (oc_lat[i] && !stb_s) |=> oc_lat[i]);
  end

  assign fault_n = ~(|oc_lat);

  // R3: latch holds while the strobe is low
  a_r3_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_s |=> $stable(out_lat));
  // R7: a strobe leaves no over-current latch behind
  a_r7_strobe_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stb_s |=> fault_n);
endmodule

// File: rtl/oswc_thermal.sv
module oswc_thermal
  import oswc_pkg::*;
#(
  parameter int TW     = 8,
  parameter int TRIP_C = 155,
  parameter int HYST_C = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] temp_code,
  output logic          hot
);
  localparam logic [TW-1:0] TRIP_V = TW'(TRIP_C);
  localparam logic [TW-1:0] LOW_V  = TW'(TRIP_C - HYST_C);

  therm_state_e st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= TH_COOL;
    else begin
      case (st_q)
        TH_COOL: if (temp_code >= TRIP_V) st_q <= TH_HOT;
        TH_HOT:  if (temp_code <  LOW_V)  st_q <= TH_COOL;
        default: st_q <= TH_COOL;
      endcase
    end
  end

  assign hot = (st_q == TH_HOT);

  // R8: inside the band the state is kept
  a_r8_stay_hot: assert property (@(posedge clk) disable iff (!rst_n)
    (hot && temp_code >= LOW_V) |=> hot);
  a_r8_stay_cool: assert property (@(posedge clk) disable iff (!rst_n)
    (!hot && temp_code < TRIP_V) |=> !hot);
endmodule

// File: rtl/octal_switch_ctrl.sv
module octal_switch_ctrl #(
  parameter int N      = 8,
  parameter int TW     = 8,
  parameter int TRIP_C = 155,
  parameter int HYST_C = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ser_clk,
  input  logic          ser_din,
  output logic          ser_dout,
  input  logic          load_stb,
  input  logic          en_n,
  input  logic [N-1:0]  oc_det,
  input  logic [TW-1:0] temp_code,
  output logic [N-1:0]  drive,
  output logic          fault_n
);
  localparam int SW = N + 4;
  localparam logic [SW-1:0] SYNC_RST = SW'(1) << 3; // enable pin resets to "disabled"

  logic [SW-1:0] raw_in, syn_in;
  logic [N-1:0]  oc_s, stage_q;
  logic          sck_s, din_s, stb_s, dis_s, hot;

  assign raw_in = {oc_det, en_n, load_stb, ser_din, ser_clk};

  oswc_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(raw_in), .q_sync(syn_in)
  );

  assign sck_s = syn_in[0];
  assign din_s = syn_in[1];
  assign stb_s = syn_in[2];
  assign dis_s = syn_in[3];
  assign oc_s  = syn_in[SW-1:4];

  oswc_shifter #(.N(N)) u_shift (
    .clk(clk), .rst_n(rst_n), .sck_s(sck_s), .din_s(din_s),
    .stage_q(stage_q), .dout(ser_dout)
  );

  oswc_thermal #(.TW(TW), .TRIP_C(TRIP_C), .HYST_C(HYST_C)) u_therm (
    .clk(clk), .rst_n(rst_n), .temp_code(temp_code), .hot(hot)
  );

  oswc_guard #(.N(N)) u_guard (
    .clk(clk), .rst_n(rst_n), .stb_s(stb_s), .dis_s(dis_s), .hot(hot),
    .oc_s(oc_s), .stage_q(stage_q), .drive(drive), .fault_n(fault_n)
  );

  // R5: a synchronized disable leaves every drive off one cycle later
  a_r5_disable_blank: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dis_s) && dis_s |-> (drive == '0));
  // R10: straight after reset nothing is driven and no fault shows
  a_r10_reset_quiet: assert property (@(posedge clk)
    $rose(rst_n) |-> (drive == '0) && fault_n && !ser_dout);
endmodule

// File: tb/test_octal_switch_ctrl.sv
`timescale 1ns/1ps
module test_octal_switch_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_clk = 1'b0, ser_din = 1'b0, load_stb = 1'b0, en_n = 1'b1;
  logic [7:0] oc_det = '0, temp_code = 8'd25;
  logic       ser_dout, fault_n;
  logic [7:0] drive;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  string      q_tag[$];
  logic [7:0] q_drv[$];
  logic       q_flt[$];
  logic       q_so[$];
  logic       q_chk_so[$];

  always #2 clk = ~clk;

  octal_switch_ctrl i_octal_switch_ctrl (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
    .ser_dout(ser_dout), .load_stb(load_stb), .en_n(en_n), .oc_det(oc_det),
    .temp_code(temp_code), .drive(drive), .fault_n(fault_n)
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver side: push one expected port state
  task automatic expect_ports(input string tag, input logic [7:0] d,
                              input logic f, input logic chk_so, input logic so);
    q_tag.push_back(tag); q_drv.push_back(d); q_flt.push_back(f);
    q_chk_so.push_back(chk_so); q_so.push_back(so);
  endtask

  task automatic shift_byte(input logic [7:0] b);
    for (int k = 7; k >= 0; k--) begin
      ser_din = b[k]; ser_clk = 1'b0; wait_cyc(4);
      ser_clk = 1'b1; wait_cyc(4);
    end
    ser_clk = 1'b0; wait_cyc(4);
  endtask

  task automatic strobe();
    load_stb = 1'b1; wait_cyc(5);
    load_stb = 1'b0; wait_cyc(5);
  endtask

  // monitor: pop and compare
  initial begin
    forever begin
      @(negedge clk); #1;
      while (q_tag.size() > 0) begin
        string t; logic [7:0] d; logic f, c, s;
        t = q_tag.pop_front(); d = q_drv.pop_front(); f = q_flt.pop_front();
        c = q_chk_so.pop_front(); s = q_so.pop_front();
        n_run++;
        if (drive !== d || fault_n !== f || (c && ser_dout !== s)) begin
          n_fail++;
          $display("FAIL %s: drive=%h fault_n=%b so=%b expected drive=%h fault_n=%b so=%b",
                   t, drive, fault_n, ser_dout, d, f, s);
        end
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    expect_ports("R10 in reset", 8'h00, 1'b1, 1'b1, 1'b0);
    wait_cyc(1);
    rst_n = 1'b1; en_n = 1'b0; wait_cyc(4);
    expect_ports("R10 after reset", 8'h00, 1'b1, 1'b1, 1'b0);

    // R1 R2 R3: shift without strobe changes no drive
    shift_byte(8'hA5);
    expect_ports("R3 no strobe yet / R2 first bit on dout", 8'h00, 1'b1, 1'b1, 1'b1);
    strobe();
    expect_ports("R1 R4 pattern A5", 8'hA5, 1'b1, 1'b1, 1'b1);

    shift_byte(8'h3C);
    expect_ports("R3 hold while strobe low / R2 dout", 8'hA5, 1'b1, 1'b1, 1'b0);
    strobe();
    expect_ports("R4 pattern 3C", 8'h3C, 1'b1, 1'b0, 1'b0);

    // R5 enable
    en_n = 1'b1; wait_cyc(4);
    expect_ports("R5 disabled", 8'h00, 1'b1, 1'b0, 1'b0);
    en_n = 1'b0; wait_cyc(4);
    expect_ports("R5 re-enabled keeps latch", 8'h3C, 1'b1, 1'b0, 1'b0);

    // R6 detect on an undriven channel is ignored
    oc_det = 8'h01; wait_cyc(4);
    expect_ports("R6 ignored on off channel", 8'h3C, 1'b1, 1'b0, 1'b0);
    oc_det = 8'h00; wait_cyc(2);

    // R6 R7 latch off channel 2
    oc_det = 8'h04; wait_cyc(4);
    expect_ports("R6 channel 2 latched off / R7 fault", 8'h38, 1'b0, 1'b0, 1'b0);
    oc_det = 8'h00; wait_cyc(4);
    expect_ports("R6 stays off after detect drops", 8'h38, 1'b0, 1'b0, 1'b0);
    strobe();
    expect_ports("R7 strobe releases channel and flag", 8'h3C, 1'b1, 1'b0, 1'b0);

    // R8 R9 thermal
    temp_code = 8'd154; wait_cyc(4);
    expect_ports("R8 below trip", 8'h3C, 1'b1, 1'b0, 1'b0);
    temp_code = 8'd155; wait_cyc(4);
    expect_ports("R8 trip / R9 no fault", 8'h00, 1'b1, 1'b0, 1'b0);
    temp_code = 8'd145; wait_cyc(4);
    expect_ports("R8 band keeps shutdown", 8'h00, 1'b1, 1'b0, 1'b0);
    temp_code = 8'd144; wait_cyc(4);
    expect_ports("R8 R9 cool restores latch", 8'h3C, 1'b1, 1'b0, 1'b0);
    temp_code = 8'd150; wait_cyc(4);
    expect_ports("R8 band keeps running", 8'h3C, 1'b1, 1'b0, 1'b0);

    // R3 transparent while strobe high, R11 latency
    load_stb = 1'b1; wait_cyc(5);
    for (int k = 0; k < 4; k++) begin
      ser_din = 1'b1; ser_clk = 1'b0; wait_cyc(4);
      ser_clk = 1'b1; wait_cyc(4);
    end
    ser_clk = 1'b0; wait_cyc(1);
    expect_ports("R3 transparent during shift / R11", 8'hCF, 1'b1, 1'b1, 1'b1);
    load_stb = 1'b0; wait_cyc(5);

    // R2 cascade: eight zeros push the ones out
    shift_byte(8'h00);
    expect_ports("R2 dout after eight zeros / R3 hold", 8'hCF, 1'b1, 1'b1, 1'b0);

    wait_cyc(4);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule